// File: doc/BRIEF.md
# Disk Sector Address Sequencer

This block holds the current disk position for one drive. In cylinder/head/sector (CHS) form it keeps three fields. In linear block (LBA) form the same three fields pack one 28-bit address. A mode input selects the form for each request. The block can step the position forward by one sector. It can turn the stored position into a linear sector number. It can also set the position from a linear sector number. The drive geometry comes in as three inputs: sectors per track, heads per cylinder and total cylinders.

Stepping, and every LBA request, completes in one cycle. A CHS convert or CHS load uses a shared iterative multiply/divide unit and keeps `busy` high while it runs. The end of every request is marked by a one-cycle `done` pulse. A range checker runs all the time and reports an ID-not-found condition for a CHS position that lies outside the programmed geometry. Sector numbering is one-based. Heads wrap at the programmed count.

Top module: `sector_addr_seq`

## Requirements
- R1: After reset the position is cylinder 0, head 0, sector 1. `lin_out` is 0, and `busy` and `done` are low.
- R2: An LBA step treats {head, cylinder, sector} (bits 27:24, 23:8, 7:0) as one 28-bit number and adds 1 to it. The value wraps from 0xFFFFFFF to 0.
- R3: A CHS step adds 1 to the sector. If the new sector is 0 (8-bit wrap) or equals sectors-per-track plus one, the sector becomes 1 and the head is advanced.
- R4: When the advanced head is 0 (4-bit wrap) or equals heads-per-cylinder, the head becomes 0 and the cylinder is incremented (16-bit wrap).
- R5: A CHS convert sets `lin_out` = (cylinder × heads + head) × spt + (sector − 1). A stored sector of 0 contributes 0.
- R6: An LBA load puts load bits 7:0 in the sector, bits 23:8 in the cylinder and bits 27:24 in the head. An LBA convert sets `lin_out` to that packing of the fields.
- R7: A CHS load sets cylinder = n / (heads × spt), head = (r / spt) and sector = (r mod spt) + 1, where r is the remainder, each truncated to its field width. If spt or heads is 0, the load leaves the position unchanged and only pulses `done`.
- R8: In CHS mode `idnf` is high when cylinder ≥ total cylinders, when head ≥ heads, or when sector is 0 or greater than spt. In LBA mode `idnf` is low.
- R9: In CHS mode, a sectors-per-track value of 0 forces `idnf` high.
- R10: `done` is a one-cycle pulse and is never high together with `busy`. Requests that arrive while `busy` is high are ignored.
- R11: Requests made in the same cycle are served in priority order: load, then step, then convert. Only one of them runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_req | input | 1 | Advance position by one sector |
| load_req | input | 1 | Set position from `load_lin` |
| conv_req | input | 1 | Compute linear number into `lin_out` |
| lba_mode | input | 1 | 1 = LBA form, 0 = CHS form |
| spt_i | input | 8 | Sectors per track (0 = unspecified) |
| heads_i | input | 5 | Heads per cylinder (1..16) |
| cyls_i | input | 16 | Total cylinders |
| load_lin | input | 28 | Linear number for a load |
| busy | output | 1 | Multi-cycle request in progress |
| done | output | 1 | One-cycle completion pulse |
| pos_cyl | output | 16 | Current cylinder field |
| pos_head | output | 4 | Current head field |
| pos_sec | output | 8 | Current sector field |
| lin_out | output | 28 | Last converted linear number |
| idnf | output | 1 | Position outside geometry (CHS) |

## Verification
The bench drives a table of CHS load/convert round trips. It then targets the carries. A sector that overflows through 0 instead of through spt+1 catches a design that compares only against the geometry; such a design would keep the head fixed. A head at 15 with 16 heads catches a head that never wraps to 0, and a sector of 0 during convert catches a design that would subtract one and underflow. The bench also checks that a step made while a CHS convert is busy does not move the position, that load wins over a step made in the same cycle, and that each bound of the range check trips `idnf`.

// File: rtl/sas_pkg.sv
package sas_pkg;
    localparam int CYL_W  = 16;
    localparam int HEAD_W = 4;
    localparam int SEC_W  = 8;
    localparam int HCNT_W = HEAD_W + 1;
    localparam int LBA_W  = CYL_W + HEAD_W + SEC_W;
    localparam int MD_W   = CYL_W + HCNT_W + SEC_W;

    // Packing order matches the linear layout: head high, sector low.
    typedef struct packed {
        logic [HEAD_W-1:0] head;
        logic [CYL_W-1:0]  cyl;
        logic [SEC_W-1:0]  sec;
    } pos_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CV_MUL,
        ST_CV_FIN,
        ST_LD_MUL,
        ST_LD_CYL,
        ST_LD_HS
    } seq_st_t;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_LOAD,
        REQ_STEP,
        REQ_CONV
    } req_t;

    function automatic req_t pick_req(input logic ld, input logic st, input logic cv);
        if (ld)      return REQ_LOAD;
        else if (st) return REQ_STEP;
        else if (cv) return REQ_CONV;
        else         return REQ_NONE;
    endfunction
endpackage

// File: rtl/sas_muldiv.sv
module sas_muldiv #(
    parameter int W = 29
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         is_div,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res_q,
    output logic [W-1:0] res_r
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt;
    logic          op_div;
    logic [W-1:0]  x;
    logic [W-1:0]  y;
    logic [W-1:0]  acc;
    logic [W:0]    trial;

    assign trial = {acc, x[W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            op_div <= 1'b0;
            x      <= '0;
            y      <= '0;
            acc    <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy   <= 1'b1;
                op_div <= is_div;
                x      <= a;
                y      <= b;
                acc    <= '0;
                cnt    <= '0;
            end else if (busy) begin
                if (op_div) begin
                    if (trial >= {1'b0, y}) begin
                        acc <= W'(trial - {1'b0, y});
                        x   <= {x[W-2:0], 1'b1};
                    end else begin
                        acc <= trial[W-1:0];
                        x   <= {x[W-2:0], 1'b0};
                    end
                end else begin
                    if (y[0]) acc <= acc + x;
                    x <= {x[W-2:0], 1'b0};
                    y <= {1'b0, y[W-1:1]};
                end
                cnt <= cnt + 1'b1;
                if (cnt == CW'(W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign res_q = op_div ? x : acc;
    assign res_r = acc;
endmodule

// File: rtl/sas_step.sv
module sas_step
    import sas_pkg::*;
(
    input  pos_t              cur,
    input  logic              lba,
    input  logic [SEC_W-1:0]  spt,
    input  logic [HCNT_W-1:0] heads,
    output pos_t              nxt
);
    logic [LBA_W-1:0]  flat;
    logic [SEC_W-1:0]  sec_inc;
    logic [SEC_W:0]    spt_p1;
    logic [HEAD_W-1:0] head_inc;

    always_comb begin
        flat     = cur;
        sec_inc  = cur.sec + 1'b1;
        spt_p1   = {1'b0, spt} + 1'b1;
        head_inc = cur.head + 1'b1;
        nxt      = cur;
        if (lba) begin
            nxt = pos_t'(flat + 1'b1);
        end else if ((sec_inc == '0) || ({1'b0, sec_inc} == spt_p1)) begin
            nxt.sec = SEC_W'(1);
            if ((head_inc == '0) || ({1'b0, head_inc} == heads)) begin
                nxt.head = '0;
                nxt.cyl  = cur.cyl + 1'b1;
            end else begin
                nxt.head = head_inc;
            end
        end else begin
            nxt.sec = sec_inc;
        end
    end
endmodule

// File: rtl/sas_range_chk.sv
module sas_range_chk
    import sas_pkg::*;
(
    input  pos_t              cur,
    input  logic              lba,
    input  logic [SEC_W-1:0]  spt,
    input  logic [HCNT_W-1:0] heads,
    input  logic [CYL_W-1:0]  cyls,
    output logic              idnf
);
    logic geo_unset;
    logic out_cyl;
    logic out_head;
    logic out_sec;

    always_comb begin
        geo_unset = (spt == '0);
        out_cyl   = (cur.cyl >= cyls);
        out_head  = ({1'b0, cur.head} >= heads);
        out_sec   = (cur.sec == '0) || (cur.sec > spt);
        idnf      = !lba && (geo_unset || out_cyl || out_head || out_sec);
    end
endmodule

// File: rtl/sector_addr_seq.sv
module sector_addr_seq
    import sas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_req,
    input  logic              load_req,
    input  logic              conv_req,
    input  logic              lba_mode,
    input  logic [SEC_W-1:0]  spt_i,
    input  logic [HCNT_W-1:0] heads_i,
    input  logic [CYL_W-1:0]  cyls_i,
    input  logic [LBA_W-1:0]  load_lin,
    output logic              busy,
    output logic              done,
    output logic [CYL_W-1:0]  pos_cyl,
    output logic [HEAD_W-1:0] pos_head,
    output logic [SEC_W-1:0]  pos_sec,
    output logic [LBA_W-1:0]  lin_out,
    output logic              idnf
);
    seq_st_t          st;
    pos_t             pos;
    pos_t             step_nxt;
    logic [LBA_W-1:0] lin_r;
    logic [MD_W-1:0]  tmp;
    logic [LBA_W-1:0] ldv;
    logic             done_r;

    logic             md_start;
    logic             md_div;
    logic [MD_W-1:0]  md_a;
    logic [MD_W-1:0]  md_b;
    logic             md_busy;
    logic             md_done;
    logic [MD_W-1:0]  md_q;
    logic [MD_W-1:0]  md_r;
    logic [MD_W-1:0]  sec_adj;
    req_t             req;

    sas_step u_step (
        .cur   (pos),
        .lba   (lba_mode),
        .spt   (spt_i),
        .heads (heads_i),
        .nxt   (step_nxt)
    );

    sas_range_chk u_range (
        .cur   (pos),
        .lba   (lba_mode),
        .spt   (spt_i),
        .heads (heads_i),
        .cyls  (cyls_i),
        .idnf  (idnf)
    );

    sas_muldiv #(.W(MD_W)) u_md (
        .clk    (clk),
        .rst    (rst),
        .start  (md_start),
        .is_div (md_div),
        .a      (md_a),
        .b      (md_b),
        .busy   (md_busy),
        .done   (md_done),
        .res_q  (md_q),
        .res_r  (md_r)
    );

    assign req     = pick_req(load_req, step_req, conv_req);
    assign sec_adj = (pos.sec == '0) ? '0 : MD_W'(pos.sec - 1'b1);
    assign md_start = (st != ST_IDLE) && !md_busy && !md_done;

    always_comb begin
        md_a   = '0;
        md_b   = '0;
        md_div = 1'b0;
        case (st)
            ST_CV_MUL: begin md_a = MD_W'(pos.cyl); md_b = MD_W'(heads_i); end
            ST_CV_FIN: begin md_a = tmp;            md_b = MD_W'(spt_i);   end
            ST_LD_MUL: begin md_a = MD_W'(heads_i); md_b = MD_W'(spt_i);   end
            ST_LD_CYL: begin md_a = MD_W'(ldv);     md_b = tmp;            md_div = 1'b1; end
            ST_LD_HS:  begin md_a = tmp;            md_b = MD_W'(spt_i);   md_div = 1'b1; end
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            pos    <= '{head: '0, cyl: '0, sec: SEC_W'(1)};
            lin_r  <= '0;
            tmp    <= '0;
            ldv    <= '0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            case (st)
                ST_IDLE: begin
                    case (req)
                        REQ_LOAD: begin
                            if (lba_mode) begin
                                pos    <= pos_t'(load_lin);
                                done_r <= 1'b1;
                            end else if (spt_i == '0 || heads_i == '0) begin
                                done_r <= 1'b1;
                            end else begin
                                ldv <= load_lin;
                                st  <= ST_LD_MUL;
                            end
                        end
                        REQ_STEP: begin
                            pos    <= step_nxt;
                            done_r <= 1'b1;
                        end
                        REQ_CONV: begin
                            if (lba_mode) begin
                                lin_r  <= pos;
                                done_r <= 1'b1;
                            end else begin
                                st <= ST_CV_MUL;
                            end
                        end
                        default: ;
                    endcase
                end
                ST_CV_MUL: if (md_done) begin
                    tmp <= md_q + MD_W'(pos.head);
                    st  <= ST_CV_FIN;
                end
                ST_CV_FIN: if (md_done) begin
                    lin_r  <= LBA_W'(md_q + sec_adj);
                    done_r <= 1'b1;
                    st     <= ST_IDLE;
                end
                ST_LD_MUL: if (md_done) begin
                    tmp <= md_q;
                    st  <= ST_LD_CYL;
                end
                ST_LD_CYL: if (md_done) begin
                    pos.cyl <= md_q[CYL_W-1:0];
                    tmp     <= md_r;
                    st      <= ST_LD_HS;
                end
                ST_LD_HS: if (md_done) begin
                    pos.head <= md_q[HEAD_W-1:0];
                    pos.sec  <= md_r[SEC_W-1:0] + 1'b1;
                    done_r   <= 1'b1;
                    st       <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign done     = done_r;
    assign pos_cyl  = pos.cyl;
    assign pos_head = pos.head;
    assign pos_sec  = pos.sec;
    assign lin_out  = lin_r;
endmodule

// File: rtl/sas_checker.sv
module sas_checker
    import sas_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              step_req,
    input logic              load_req,
    input logic              lba_mode,
    input logic [SEC_W-1:0]  spt_i,
    input logic              busy,
    input logic              done,
    input logic [CYL_W-1:0]  pos_cyl,
    input logic [HEAD_W-1:0] pos_head,
    input logic [SEC_W-1:0]  pos_sec,
    input logic              idnf
);
    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_ends_done_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_idnf_lba_low_R8: assert property (@(posedge clk) disable iff (rst)
        lba_mode |-> !idnf);

    assert_spt_zero_idnf_R9: assert property (@(posedge clk) disable iff (rst)
        (!lba_mode && spt_i == '0) |-> idnf);

    assert_lba_step_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && step_req && !load_req && lba_mode) |=>
        ({pos_head, pos_cyl, pos_sec} == LBA_W'($past({pos_head, pos_cyl, pos_sec}) + 1'b1)));

    assert_chs_step_sec_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && step_req && !load_req && !lba_mode && spt_i != '0 &&
         pos_sec != '0 && pos_sec < spt_i) |=>
        (pos_sec == SEC_W'($past(pos_sec) + 1'b1)) && $stable(pos_head));
endmodule

bind sector_addr_seq sas_checker u_chk (.*);

// File: tb/sector_addr_seq_bench.sv
module sector_addr_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_req = 1'b0, load_req = 1'b0, conv_req = 1'b0;
    logic        lba_mode = 1'b0;
    logic [7:0]  spt_i = 8'd63;
    logic [4:0]  heads_i = 5'd16;
    logic [15:0] cyls_i = 16'hFFFF;
    logic [27:0] load_lin = '0;
    logic        busy, done, idnf;
    logic [15:0] pos_cyl;
    logic [3:0]  pos_head;
    logic [7:0]  pos_sec;
    logic [27:0] lin_out;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sector_addr_seq u_sector_addr_seq (.*);

    // {lin[68:41], spt[40:33], heads[32:28], cyl[27:12], head[11:8], sec[7:0]}
    localparam int NV = 6;
    localparam logic [NV-1:0][68:0] VEC = {
        {28'd0,      8'd63,  5'd16, 16'd0,    4'd0,  8'd1},
        {28'd1007,   8'd63,  5'd16, 16'd0,    4'd15, 8'd63},
        {28'd1008,   8'd63,  5'd16, 16'd1,    4'd0,  8'd1},
        {28'd123456, 8'd17,  5'd4,  16'd1815, 4'd2,  8'd3},
        {28'd5000,   8'd255, 5'd16, 16'd1,    4'd3,  8'd156},
        {28'd99,     8'd1,   5'd1,  16'd99,   4'd0,  8'd1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk("R10 done seen", {31'd0, done}, 32'd1);
    endtask

    task automatic req(input logic ld, input logic st, input logic cv);
        @(negedge clk);
        load_req = ld; step_req = st; conv_req = cv;
        @(negedge clk);
        load_req = 1'b0; step_req = 1'b0; conv_req = 1'b0;
        wait_done();
    endtask

    task automatic chk_pos(input string tag, input logic [15:0] c, input logic [3:0] h, input logic [7:0] s);
        chk({tag, " cyl"},  {16'd0, pos_cyl}, {16'd0, c});
        chk({tag, " head"}, {28'd0, pos_head}, {28'd0, h});
        chk({tag, " sec"},  {24'd0, pos_sec}, {24'd0, s});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] ssave;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_pos("R1 reset", 16'd0, 4'd0, 8'd1);
        chk("R1 lin", {4'd0, lin_out}, 32'd0);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);

        // Table: CHS load then convert round trip (R7, R5)
        for (int i = 0; i < NV; i++) begin
            lba_mode = 1'b0;
            load_lin = VEC[i][68:41];
            spt_i    = VEC[i][40:33];
            heads_i  = VEC[i][32:28];
            req(1'b1, 1'b0, 1'b0);
            chk_pos("R7 chs load", VEC[i][27:12], VEC[i][11:8], VEC[i][7:0]);
            req(1'b0, 1'b0, 1'b1);
            chk("R5 chs convert", {4'd0, lin_out}, {4'd0, VEC[i][68:41]});
        end

        // R3/R4 carry chain, spt=2 heads=2
        lba_mode = 1'b0; spt_i = 8'd2; heads_i = 5'd2; load_lin = 28'd0;
        req(1'b1, 1'b0, 1'b0);
        req(1'b0, 1'b1, 1'b0); chk_pos("R3 step sec", 16'd0, 4'd0, 8'd2);
        req(1'b0, 1'b1, 1'b0); chk_pos("R3 sec wrap", 16'd0, 4'd1, 8'd1);
        req(1'b0, 1'b1, 1'b0); chk_pos("R3 step sec2", 16'd0, 4'd1, 8'd2);
        req(1'b0, 1'b1, 1'b0); chk_pos("R4 head wrap", 16'd1, 4'd0, 8'd1);

        // R3 sector overflow through zero
        lba_mode = 1'b1; load_lin = 28'h00000FF;
        req(1'b1, 1'b0, 1'b0);
        lba_mode = 1'b0; spt_i = 8'd255; heads_i = 5'd16;
        req(1'b0, 1'b1, 1'b0); chk_pos("R3 sec zero wrap", 16'd0, 4'd1, 8'd1);

        // R4 head overflow through zero (head 15, 16 heads)
        lba_mode = 1'b1; load_lin = 28'hF000502;
        req(1'b1, 1'b0, 1'b0);
        lba_mode = 1'b0; spt_i = 8'd2; heads_i = 5'd16;
        req(1'b0, 1'b1, 1'b0); chk_pos("R4 head zero wrap", 16'd6, 4'd0, 8'd1);

        // R5 sector 0 counts as 0
        lba_mode = 1'b1; load_lin = 28'h0000100;
        req(1'b1, 1'b0, 1'b0);
        lba_mode = 1'b0; spt_i = 8'd10; heads_i = 5'd2;
        req(1'b0, 1'b0, 1'b1);
        chk("R5 sec zero convert", {4'd0, lin_out}, 32'd20);

        // R2 LBA step
        lba_mode = 1'b1; load_lin = 28'hFFFFFFF;
        req(1'b1, 1'b0, 1'b0);
        req(1'b0, 1'b1, 1'b0);
        req(1'b0, 1'b0, 1'b1);
        chk("R2 lba wrap", {4'd0, lin_out}, 32'd0);
        load_lin = 28'h00000FF;
        req(1'b1, 1'b0, 1'b0);
        req(1'b0, 1'b1, 1'b0);
        chk_pos("R2 lba carry", 16'd1, 4'd0, 8'd0);

        // R6 LBA field split and packing
        load_lin = 28'hA1234BC;
        req(1'b1, 1'b0, 1'b0);
        chk_pos("R6 lba load", 16'h1234, 4'hA, 8'hBC);
        req(1'b0, 1'b0, 1'b1);
        chk("R6 lba convert", {4'd0, lin_out}, 32'h0A1234BC);

        // R11 load wins over step
        load_lin = 28'h0000010;
        req(1'b1, 1'b1, 1'b0);
        chk("R11 load over step", {24'd0, pos_sec}, 32'h10);

        // R8 range check bounds
        lba_mode = 1'b0; spt_i = 8'd63; heads_i = 5'd16; cyls_i = 16'd100;
        load_lin = 28'd1007;
        req(1'b1, 1'b0, 1'b0);
        @(negedge clk); chk("R8 in range", {31'd0, idnf}, 32'd0);
        cyls_i = 16'd0;
        @(negedge clk); chk("R8 cyl bound", {31'd0, idnf}, 32'd1);
        cyls_i = 16'd100; heads_i = 5'd15;
        @(negedge clk); chk("R8 head bound", {31'd0, idnf}, 32'd1);
        heads_i = 5'd16; spt_i = 8'd62;
        @(negedge clk); chk("R8 sec bound", {31'd0, idnf}, 32'd1);
        spt_i = 8'd63; lba_mode = 1'b1;
        @(negedge clk); chk("R8 lba no idnf", {31'd0, idnf}, 32'd0);
        load_lin = 28'h0000100;
        req(1'b1, 1'b0, 1'b0);
        lba_mode = 1'b0;
        @(negedge clk); chk("R8 sec zero", {31'd0, idnf}, 32'd1);

        // R9 / R7 unspecified geometry
        lba_mode = 1'b0; spt_i = 8'd63; load_lin = 28'd1007;
        req(1'b1, 1'b0, 1'b0);
        spt_i = 8'd0;
        @(negedge clk); chk("R9 spt zero idnf", {31'd0, idnf}, 32'd1);
        load_lin = 28'd5;
        req(1'b1, 1'b0, 1'b0);
        chk_pos("R7 load spt zero unchanged", 16'd0, 4'd15, 8'd63);

        // R10 step ignored while busy, done one cycle
        spt_i = 8'd63; heads_i = 5'd16; load_lin = 28'd1008;
        req(1'b1, 1'b0, 1'b0);
        ssave = pos_sec;
        @(negedge clk); conv_req = 1'b1;
        @(negedge clk); conv_req = 1'b0;
        chk("R10 busy high", {31'd0, busy}, 32'd1);
        step_req = 1'b1;
        @(negedge clk); step_req = 1'b0;
        wait_done();
        chk("R10 convert result", {4'd0, lin_out}, 32'd1008);
        chk("R10 step ignored", {24'd0, pos_sec}, {24'd0, ssave});
        @(negedge clk);
        chk("R10 done pulse", {31'd0, done}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule